// File: doc/BRIEF.md
# Address Strobe Gating Unit

This unit produces the external address strobe pin of a small microcontroller bus. A strobe pulse of fixed width starts on every machine-cycle tick. An 8-bit auxiliary configuration register can turn the pulse off. The register sits at address 8Eh on the internal special-register bus. When its bit 0 (strobe-off) is set, the pin stays low while the core fetches from on-chip program memory. This cuts switching noise. The register also holds the auxiliary RAM enable (bit 4) and the two-bit wake delay select (bits 2–1). These fields go out on ports for neighbouring blocks.

Suppression is decided again at every tick. It is not a fixed gate. With strobe-off set, a tick whose bus cycle is an external code fetch or an external data read/write still makes a full pulse. The first tick that carries an internal cycle again ends any pulse still in progress and keeps the pin low. The bus sequencer that produces the tick and the cycle kind is outside this block.

Top module: `alegate_top`

## Requirements
- R1: After a synchronous active-low reset, reading address 8Eh returns E8h, `ale_pin` is low, `aux_ram_en` is 0 and `wake_sel` is 00.
- R2: A write to address 8Eh updates bits 4, 2, 1 and 0 from the next clock edge. Bits 7–5 and bit 3 always read back as 1 and ignore writes. A read of any other address returns 00h. A write to any other address leaves the register unchanged.
- R3: With bit 0 clear, every tick raises `ale_pin` for exactly PULSE_LEN clocks (default 2), starting at the clock edge that samples the tick. This holds for every cycle kind: 00 idle, 01 internal fetch, 10 external fetch, 11 external data.
- R4: With bit 0 set, a tick whose cycle kind is 00 or 01 leaves `ale_pin` low.
- R5: With bit 0 set, a tick whose cycle kind is 10 or 11 produces a full PULSE_LEN-clock pulse.
- R6: A tick of kind 00 or 01 with bit 0 set ends a pulse that is still running from an earlier external cycle. `ale_pin` is low from that edge on.
- R7: A tick that arrives while a pulse is running, and whose pulse is allowed, restarts the pulse width from that edge. `ale_pin` is never high for more than PULSE_LEN clocks after the last tick.
- R8: `aux_ram_en` follows register bit 4 and `wake_sel` follows bits 2–1. Suppression is decided with the bit 0 value held before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Write address |
| cfg_wdata | input | 8 | Write data |
| cfg_raddr | input | 8 | Read address |
| cfg_rdata | output | 8 | Read data (combinational) |
| cyc_kind | input | 2 | Bus cycle kind: 00 idle, 01 internal fetch, 10 external fetch, 11 external data |
| cyc_tick | input | 1 | Machine-cycle phase tick, one clock wide |
| ale_pin | output | 1 | Address strobe pin |
| aux_ram_en | output | 1 | Auxiliary RAM enable field |
| wake_sel | output | 2 | Wake delay select field |

## Verification
The hardest case to reach from the ports is an internal tick that arrives while a pulse from an external cycle is still high. The same tick may also come with a register write that flips the strobe-off bit. To reach it, the stimulus issues ticks at spacings shorter than PULSE_LEN and alternates external and internal kinds back to back. It also writes the register in the very cycles that carry a tick. A behavioural model tracks the remaining pulse time as an integer and is compared with the pin on every clock.

// File: rtl/alegate_pkg.sv
// Package alegate_pkg
// Shared types for the address strobe gating unit: the bus cycle kind
// encoding and the decoded fields of the auxiliary configuration register.
package alegate_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE     = 2'b00,
        CYC_INT_FTCH = 2'b01,
        CYC_EXT_FTCH = 2'b10,
        CYC_EXT_DATA = 2'b11
    } cyc_kind_t;

    typedef struct packed {
        logic       ram_en;
        logic [1:0] wake;
        logic       strobe_off;
    } aux_fields_t;

    localparam logic [7:0] RSVD_MASK = 8'b1110_1000;

    function automatic logic [7:0] pack_aux(input aux_fields_t f);
        return RSVD_MASK | {3'b000, f.ram_en, 1'b0, f.wake, f.strobe_off};
    endfunction

endpackage

// File: rtl/alegate_cfg.sv
// Module alegate_cfg
// Holds the auxiliary configuration register. Writes hit only when the
// address equals REG_ADDR. Reserved bits are not stored and read as 1.
// Assumes a single-cycle write strobe and a combinational read path.
module alegate_cfg
    import alegate_pkg::*;
#(
    parameter int         AW       = 8,
    parameter int         DW       = 8,
    parameter logic [7:0] REG_ADDR = 8'h8E
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output aux_fields_t   fields
);

    aux_fields_t fld_q;
    logic        hit_w;
    logic        hit_r;

    assign hit_w = we && (waddr == AW'(REG_ADDR));
    assign hit_r = (raddr == AW'(REG_ADDR));

    // Store the writable fields on an address match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_q <= '0;
        end else if (hit_w) begin
            fld_q.ram_en     <= wdata[4];
            fld_q.wake       <= wdata[2:1];
            fld_q.strobe_off <= wdata[0];
        end
    end

    // Return the packed register on a match, zero elsewhere.
    always_comb begin
        rdata = '0;
        if (hit_r) rdata = DW'(pack_aux(fld_q));
    end

    assign fields = fld_q;

    // R1
    reset_value_chk: assert property (@(posedge clk)
        !rst_n |=> (fld_q == '0));

    // R2
    rsvd_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_r |-> (rdata[7:5] == 3'b111 && rdata[3]));

    // R2
    miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_w && rst_n) |=> $stable(fld_q));

endmodule

// File: rtl/alegate_gate.sv
// Module alegate_gate
// Decides at each tick whether a strobe pulse may start. External code
// or data cycles always qualify. Other kinds qualify only when the
// strobe-off field is clear. Pure combinational logic.
module alegate_gate
    import alegate_pkg::*;
(
    input  logic        strobe_off,
    input  cyc_kind_t   kind,
    output logic        grant
);

    logic is_ext;

    // Classify the cycle kind as external or on-chip.
    always_comb begin
        unique case (kind)
            CYC_EXT_FTCH, CYC_EXT_DATA: is_ext = 1'b1;
            default:                    is_ext = 1'b0;
        endcase
    end

    assign grant = is_ext || !strobe_off;

endmodule

// File: rtl/alegate_pulse.sv
// Module alegate_pulse
// Shapes the strobe. Each tick reloads the width counter when granted,
// or forces the output low when not. Between ticks the pulse runs out.
// Assumes PULSE_LEN >= 1 and ticks of one clock.
module alegate_pulse #(
    parameter int PULSE_LEN = 2,
    localparam int CW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic grant,
    output logic pulse
);

    logic [CW-1:0] cnt_q;
    logic          out_q;

    // Restart, cut or run down the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else if (tick) begin
            out_q <= grant;
            cnt_q <= grant ? CW'(PULSE_LEN - 1) : '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else begin
            out_q <= 1'b0;
        end
    end

    assign pulse = out_q;

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(PULSE_LEN - 1));

    // R7
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && cnt_q == '0) |=> !out_q);

endmodule

// File: rtl/alegate_top.sv
// Module alegate_top
// Address strobe gating unit: configuration register, per-tick gate
// decision and pulse shaper. Each tick uses the strobe-off value held
// before any write in the same cycle.
module alegate_top
    import alegate_pkg::*;
#(
    parameter int         AW        = 8,
    parameter int         DW        = 8,
    parameter logic [7:0] REG_ADDR  = 8'h8E,
    parameter int         PULSE_LEN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    input  logic [AW-1:0] cfg_raddr,
    output logic [DW-1:0] cfg_rdata,
    input  logic [1:0]    cyc_kind,
    input  logic          cyc_tick,
    output logic          ale_pin,
    output logic          aux_ram_en,
    output logic [1:0]    wake_sel
);

    aux_fields_t fields;
    logic        grant;

    alegate_cfg #(.AW(AW), .DW(DW), .REG_ADDR(REG_ADDR)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .waddr  (cfg_addr),
        .wdata  (cfg_wdata),
        .raddr  (cfg_raddr),
        .rdata  (cfg_rdata),
        .fields (fields)
    );

    alegate_gate u_gate (
        .strobe_off (fields.strobe_off),
        .kind       (cyc_kind_t'(cyc_kind)),
        .grant      (grant)
    );

    alegate_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (cyc_tick),
        .grant (grant),
        .pulse (ale_pin)
    );

    assign aux_ram_en = fields.ram_en;
    assign wake_sel   = fields.wake;

    // R3
    on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_tick && !fields.strobe_off) |=> ale_pin);

    // R4
    int_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_tick && fields.strobe_off && !cyc_kind[1]) |=> !ale_pin);

    // R5
    ext_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_tick && cyc_kind[1]) |=> ale_pin);

endmodule

// File: tb/test_alegate_top.sv
// Bench for alegate_top: behavioural model with an integer count of the
// pulse time left, compared with every output at each falling edge.
module test_alegate_top;

    localparam int P = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_raddr = 8'h8E;
    logic [7:0] cfg_rdata;
    logic [1:0] cyc_kind = '0;
    logic       cyc_tick = 1'b0;
    logic       ale_pin;
    logic       aux_ram_en;
    logic [1:0] wake_sel;

    int checks = 0;
    int errors = 0;

    // model state
    int       rem = 0;
    bit       m_off = 0, m_ram = 0;
    bit [1:0] m_ws = 0;
    string    ale_tag = "R1";

    always #2 clk = ~clk;

    alegate_top #(.PULSE_LEN(P)) i_alegate_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .cyc_kind(cyc_kind), .cyc_tick(cyc_tick), .ale_pin(ale_pin),
        .aux_ram_en(aux_ram_en), .wake_sel(wake_sel)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            rem = 0; m_off = 0; m_ram = 0; m_ws = 0; ale_tag = "R1";
        end else begin
            if (cyc_tick) begin
                if (!m_off) begin rem = P; ale_tag = "R3"; end
                else if (cyc_kind[1]) begin
                    rem = P; ale_tag = (rem > 0 && ale_pin) ? "R7" : "R5";
                end else begin
                    ale_tag = ale_pin ? "R6" : "R4"; rem = 0;
                end
            end else if (rem > 0) rem--;
            if (cfg_we && cfg_addr == 8'h8E) begin
                m_off = cfg_wdata[0]; m_ws = cfg_wdata[2:1]; m_ram = cfg_wdata[4];
            end
        end
    end

    // Compare at falling edges, away from the active edge.
    always @(negedge clk) begin
        if (rst_n !== 1'bx) begin
            logic [7:0] er;
            er = (cfg_raddr == 8'h8E) ? (8'hE8 | {3'b0, m_ram, 1'b0, m_ws, m_off}) : 8'h00;
            chk(ale_tag, int'(ale_pin), int'(rem > 0));
            chk("R2", int'(cfg_rdata), int'(er));
            chk("R8", int'({aux_ram_en, wake_sel}), int'({m_ram, m_ws}));
        end
    end

    task automatic cyc(input bit t, input logic [1:0] k);
        @(negedge clk); #1;
        cfg_we = 0; cyc_tick = t; cyc_kind = k;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit t, input logic [1:0] k);
        @(negedge clk); #1;
        cfg_we = 1; cfg_addr = a; cfg_wdata = d; cyc_tick = t; cyc_kind = k;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        // R1 reset state observed by the comparator
        @(negedge clk);
        chk("R1", int'(cfg_rdata), 8'hE8);
        // R3 all kinds pulse with strobe-off clear
        for (int k = 0; k < 4; k++) begin
            cyc(1, 2'(k)); repeat (4) cyc(0, 2'(k));
        end
        // R2 writes to other address ignored, foreign read returns zero
        wr(8'h8F, 8'hFF, 0, 0); cyc(0, 0);
        cfg_raddr = 8'h10; cyc(0, 0); cfg_raddr = 8'h8E;
        // R2 R8 set all writable bits, reserved written as zero
        wr(8'h8E, 8'h17, 0, 0); cyc(0, 0);
        // R4 internal and idle ticks quiet
        cyc(1, 2'b01); cyc(0, 1); cyc(0, 1); cyc(1, 2'b00); cyc(0, 0); cyc(0, 0);
        // R5 external fetch and data pulse
        cyc(1, 2'b10); repeat (3) cyc(0, 2); cyc(1, 2'b11); repeat (3) cyc(0, 3);
        // R6 internal tick cuts an external pulse
        cyc(1, 2'b11); cyc(1, 2'b01); cyc(0, 1); cyc(0, 1);
        // R7 back-to-back external ticks restart
        cyc(1, 2'b10); cyc(1, 2'b10); cyc(0, 2); cyc(0, 2); cyc(0, 2);
        // R8 write in same cycle as a tick uses old bit 0
        wr(8'h8E, 8'h00, 1, 2'b01); cyc(0, 1); cyc(0, 1);
        wr(8'h8E, 8'h01, 1, 2'b01); cyc(0, 1); cyc(0, 1); cyc(1, 2'b01); cyc(0, 1);
        // mixed stimulus
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 16) == 0) wr(8'h8E, 8'($urandom), ($urandom % 3) == 0, 2'($urandom));
            else cyc(($urandom % 3) == 0, 2'($urandom));
        end
        // R1 reset again mid-pulse
        cyc(1, 2'b11); #1 rst_n = 0; cyc(0, 0); cyc(0, 0); #1 rst_n = 1;
        cyc(0, 0);
        chk("R1", int'(cfg_rdata), 8'hE8);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule